// File: doc/BRIEF.md
# Banked Monitor Register Port

This block is the register side of a hardware-monitor device as seen from an 8-bit host bus. The host reaches it through two byte ports: one holds a 7-bit pointer (the index), and the other reads or writes the register that the pointer selects. Behind the pointer are three kinds of register. Live sensor readouts come from input ports: seven voltage bytes, one temperature byte and three fan counts. There is a 32-byte control file with reset defaults. There are two small auxiliary temperature sets, and the host reaches them by changing the active bank.

For fast sequential reads of value tables, the port steps the pointer forward by itself after data accesses to a chosen group of registers. Indexes 0x60 to 0x7F are a second view of the control file at 0x40 to 0x5F. Some registers refuse writes. The host can return the whole control state to its defaults by setting the top bit of the configuration register. Fan counts are turned from rpm into period counts using the divisor fields held in the control file.

Top module: `hwmon_regport`

## Requirements
- R1: A write to the pointer port (bus_sel=0) loads bits 6:0 of the data and drops bit 7. A read of the pointer port returns the pointer with bit 7 at 0. Reset clears the pointer to 0x00.
- R2: When bank 0 is active, a data-port access (read or write) at pointer 0x41, 0x43, 0x45, 0x56, or any pointer from 0x60 to 0x7E, adds 1 to the pointer afterwards. No other access changes the pointer by itself, and this includes every access made while bank 1 or 2 is active.
- R3: Pointers 0x60 to 0x7F read and write the same storage as 0x40 to 0x5F. Bits 4:0 of the pointer select the byte.
- R4: Writes are ignored at 0x20–0x2A, 0x41, 0x42, 0x4F and 0x58. A write through pointers 0x60–0x6A is also ignored, even when the byte at the matching 0x40–0x4A location is writable.
- R5: A read of 0x4F (or its alias 0x6F) returns 0x5C when bit 7 of register 0x4E is 1, and 0xA3 when that bit is 0.
- R6: A write to 0x4E selects the active bank from bits 2:0 of the data. Bit 0 selects bank 0 and wins over the other bits. Bit 1 selects bank 1 and wins over bit 2. Bit 2 alone selects bank 2. When none of the three bits is set, the bank does not change. Reset selects bank 0.
- R7: When bank 1 or 2 is active, pointers 0x50 to 0x5F (but not their aliases at 0x70 to 0x7F) reach that bank's own set. In that set, 0x50 reads the bank's temperature input and 0x51 reads 0x00, and neither accepts a write. 0x52 to 0x55 are writable bytes that belong to the bank. 0x56 to 0x5F read 0x00 and ignore writes.
- R8: A write to 0x40 that is accepted and has data bit 7 set puts the control file back to its defaults, clears both auxiliary sets and selects bank 0. The pointer keeps its value.
- R9: After reset the control file holds 0x40=0x01, 0x46=0x40, 0x47=0x50, 0x49=0x02, 0x4B=0x44, 0x4C=0x01, 0x4D=0x15, 0x4E=0x80 and 0x57=0x80. Every other byte holds 0x00.
- R10: A read of 0x20 to 0x26 returns voltage byte 0 to 6 (volt_in[8k+7:8k] at 0x20+k). A read of 0x27 returns temp_main.
- R11: A read of 0x28, 0x29 or 0x2A returns the count for fan 0, 1 or 2. The count is 1350000 divided by (rpm × 2^f), truncated and limited to the range 1 to 255, and 255 when rpm is 0. The field f is bits 5:4 of 0x47 for fan 0, bits 7:6 of 0x47 for fan 1, and bits 7:6 of 0x4B for fan 2.
- R12: Pointers 0x00–0x1F and 0x2B–0x3F read 0x00 and ignore writes.
- R13: bus_rdata is a register cleared by reset. It takes a new value only on the clock edge that samples a read (bus_en=1, bus_wr=0) and holds that value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = pointer port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| volt_in | input | 56 | Seven voltage readout bytes |
| temp_main | input | 8 | Main temperature readout |
| temp_aux | input | 16 | Temperature readout for bank 1 (bits 7:0) and bank 2 (bits 15:8) |
| fan_rpm | input | 48 | Three 16-bit fan speeds in rpm, fan 0 in the low bits |

## Verification
Pointer walks go through the step-on-access registers and end at the edges of the alias window, 0x7E and 0x7F, so a pointer that stops a step too early or too late shows up. The same bytes are written through both views, first in bank 0 and then in banks 1 and 2. This separates bank-local storage from shared storage, and it shows whether the alias window itself is kept out of bank switching. The bank-select patterns have one, two and three bits set, or none, which tests the priority order and the rule that an empty pattern keeps the bank. The fan counts are checked once with the default divisors and again after the divisor fields change, including one fan stopped at 0 rpm.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;
  localparam int DW         = 8;
  localparam int IW         = 7;
  localparam int MAIN_DEPTH = 32;
  localparam int MAIN_AW    = $clog2(MAIN_DEPTH);
  localparam int VOLT_N     = 7;
  localparam int FAN_N      = 3;
  localparam int AUX_N      = 2;
  localparam int AUX_AW     = 4;
  localparam int AUX_SLOTS  = 4;

  localparam logic [IW-1:0] IDX_VOLT   = 7'h20;
  localparam logic [IW-1:0] IDX_TEMP   = 7'h27;
  localparam logic [IW-1:0] IDX_FAN    = 7'h28;
  localparam logic [IW-1:0] IDX_FANEND = 7'h2B;
  localparam logic [IW-1:0] IDX_MAIN   = 7'h40;
  localparam logic [IW-1:0] IDX_ALIAS  = 7'h60;
  localparam logic [IW-1:0] IDX_ALRO   = 7'h6A;
  localparam logic [IW-1:0] IDX_LAST   = 7'h7E;

  localparam logic [MAIN_AW-1:0] OFS_CFG   = 5'h00;
  localparam logic [MAIN_AW-1:0] OFS_DIVA  = 5'h07;
  localparam logic [MAIN_AW-1:0] OFS_DIVB  = 5'h0B;
  localparam logic [MAIN_AW-1:0] OFS_BANK  = 5'h0E;
  localparam logic [MAIN_AW-1:0] OFS_VID   = 5'h0F;

  function automatic logic [DW-1:0] main_default(input logic [MAIN_AW-1:0] a);
    case (a)
      5'h00: return 8'h01;
      5'h06: return 8'h40;
      5'h07: return 8'h50;
      5'h09: return 8'h02;
      5'h0B: return 8'h44;
      5'h0C: return 8'h01;
      5'h0D: return 8'h15;
      5'h0E: return 8'h80;
      5'h17: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic main_ro(input logic [MAIN_AW-1:0] a);
    return (a == 5'h01) || (a == 5'h02) || (a == OFS_VID) || (a == 5'h18);
  endfunction
endpackage

// File: rtl/hwmon_fan_count.sv
module hwmon_fan_count #(
  parameter int RPM_W     = 16,
  parameter int FAN_CONST = 1350000
) (
  input  logic [RPM_W-1:0] rpm,
  input  logic [1:0]       div_sel,
  output logic [7:0]       count
);
  localparam int PW = RPM_W + 3;
  localparam logic [31:0] K = 32'(FAN_CONST);

  logic [PW-1:0] prod;
  logic [31:0]   quot;

  always_comb begin
    prod = {3'b000, rpm} << div_sel;
    quot = (prod == '0) ? 32'd0 : K / 32'(prod);
    if (prod == '0 || quot > 32'd255) count = 8'hFF;
    else if (quot == 32'd0)           count = 8'h01;
    else                              count = quot[7:0];
  end
endmodule

// File: rtl/hwmon_aux_bank.sv
module hwmon_aux_bank
  import hwmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              we,
  input  logic [AUX_AW-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [AUX_AW-1:0] raddr,
  input  logic [DW-1:0]     temp,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] slot_q [AUX_SLOTS];
  logic [1:0]    wslot, rslot;

  assign wslot = 2'(waddr - 4'd2);
  assign rslot = 2'(raddr - 4'd2);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      for (int k = 0; k < AUX_SLOTS; k++) slot_q[k] <= '0;
    end else if (we) begin
      slot_q[wslot] <= wdata;
    end
  end

  always_comb begin
    case (raddr)
      4'h0:                      rdata = temp;
      4'h2, 4'h3, 4'h4, 4'h5:    rdata = slot_q[rslot];
      default:                   rdata = '0;
    endcase
  end

  assert_aux_wr_window_R7: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr >= 4'd2 && waddr <= 4'd5));
endmodule

// File: rtl/hwmon_main_file.sv
module hwmon_main_file
  import hwmon_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               init,
  input  logic               we,
  input  logic [MAIN_AW-1:0] waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [MAIN_AW-1:0] raddr,
  output logic [DW-1:0]      rdata,
  output logic [DW-1:0]      div_a,
  output logic [DW-1:0]      div_b,
  output logic [DW-1:0]      bank_cfg
);
  logic [DW-1:0] mem_q [MAIN_DEPTH];

  always_ff @(posedge clk) begin
    if (rst || init) begin
      for (int k = 0; k < MAIN_DEPTH; k++) mem_q[k] <= main_default(MAIN_AW'(k));
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata    = mem_q[raddr];
  assign div_a    = mem_q[OFS_DIVA];
  assign div_b    = mem_q[OFS_DIVB];
  assign bank_cfg = mem_q[OFS_BANK];

  assert_ro_guard_R4: assert property (@(posedge clk) disable iff (rst)
    we |-> !main_ro(waddr));
endmodule

// File: rtl/hwmon_regport.sv
module hwmon_regport
  import hwmon_pkg::*;
#(
  parameter int          RPM_W     = 16,
  parameter int          FAN_CONST = 1350000,
  parameter logic [15:0] VENDOR_ID = 16'h5CA3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_en,
  input  logic                   bus_wr,
  input  logic                   bus_sel,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [VOLT_N*DW-1:0]   volt_in,
  input  logic [DW-1:0]          temp_main,
  input  logic [AUX_N*DW-1:0]    temp_aux,
  input  logic [FAN_N*RPM_W-1:0] fan_rpm
);
  logic [IW-1:0] idx_q;
  logic [1:0]    bank_q;
  logic [DW-1:0] rdata_q;

  logic data_acc, data_wr, aux_hit, main_hit, alias_ro, step_hit;
  logic main_we, init_req, banksel_wr;
  logic [MAIN_AW-1:0] eff;
  logic [DW-1:0] file_rd, div_a, div_b, bank_cfg, rd_val;
  logic [DW-1:0] aux_rd [AUX_N];
  logic [AUX_N-1:0] aux_we;
  logic [1:0] fan_div [FAN_N];
  logic [7:0] fan_cnt [FAN_N];

  assign data_acc = bus_en && bus_sel;
  assign data_wr  = data_acc && bus_wr;
  assign aux_hit  = (bank_q != 2'd0) && (idx_q[6:4] == 3'h5);
  assign main_hit = !aux_hit && (idx_q >= IDX_MAIN);
  assign eff      = idx_q[MAIN_AW-1:0];
  assign alias_ro = (idx_q >= IDX_ALIAS) && (idx_q <= IDX_ALRO);
  assign main_we  = data_wr && main_hit && !alias_ro && !main_ro(eff);
  assign init_req = main_we && (eff == OFS_CFG) && bus_wdata[7];
  assign banksel_wr = main_we && (eff == OFS_BANK);
  assign step_hit = (bank_q == 2'd0) &&
                    ((idx_q == 7'h41) || (idx_q == 7'h43) || (idx_q == 7'h45) ||
                     (idx_q == 7'h56) || (idx_q >= IDX_ALIAS && idx_q <= IDX_LAST));

  hwmon_main_file u_file (
    .clk(clk), .rst(rst), .init(init_req), .we(main_we), .waddr(eff),
    .wdata(bus_wdata), .raddr(eff), .rdata(file_rd),
    .div_a(div_a), .div_b(div_b), .bank_cfg(bank_cfg)
  );

  for (genvar b = 0; b < AUX_N; b++) begin : g_aux
    assign aux_we[b] = data_wr && aux_hit && (bank_q == 2'(b + 1)) &&
                       (idx_q[3:0] >= 4'd2) && (idx_q[3:0] <= 4'd5);
    hwmon_aux_bank u_bank (
      .clk(clk), .rst(rst), .init(init_req), .we(aux_we[b]),
      .waddr(idx_q[AUX_AW-1:0]), .wdata(bus_wdata), .raddr(idx_q[AUX_AW-1:0]),
      .temp(temp_aux[b*DW +: DW]), .rdata(aux_rd[b])
    );
  end

  always_comb begin
    fan_div[0] = div_a[5:4];
    fan_div[1] = div_a[7:6];
    fan_div[2] = div_b[7:6];
  end

  for (genvar f = 0; f < FAN_N; f++) begin : g_fan
    hwmon_fan_count #(.RPM_W(RPM_W), .FAN_CONST(FAN_CONST)) u_fan (
      .rpm(fan_rpm[f*RPM_W +: RPM_W]), .div_sel(fan_div[f]), .count(fan_cnt[f])
    );
  end

  always_comb begin
    rd_val = '0;
    if (idx_q < IDX_VOLT)             rd_val = '0;
    else if (idx_q < IDX_TEMP)        rd_val = volt_in[idx_q[2:0]*DW +: DW];
    else if (idx_q == IDX_TEMP)       rd_val = temp_main;
    else if (idx_q < IDX_FANEND)      rd_val = fan_cnt[idx_q[1:0]];
    else if (idx_q < IDX_MAIN)        rd_val = '0;
    else if (aux_hit) begin
      for (int b = 0; b < AUX_N; b++)
        if (bank_q == 2'(b + 1)) rd_val = aux_rd[b];
    end
    else if (eff == OFS_VID)          rd_val = bank_cfg[7] ? VENDOR_ID[15:8] : VENDOR_ID[7:0];
    else                              rd_val = file_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      bank_q  <= 2'd0;
      rdata_q <= '0;
    end else begin
      if (bus_en && !bus_wr) rdata_q <= bus_sel ? rd_val : {1'b0, idx_q};
      if (bus_en && bus_wr && !bus_sel) idx_q <= bus_wdata[IW-1:0];
      else if (data_acc && step_hit)    idx_q <= idx_q + 7'd1;
      if (init_req)                     bank_q <= 2'd0;
      else if (banksel_wr) begin
        if (bus_wdata[0])      bank_q <= 2'd0;
        else if (bus_wdata[1]) bank_q <= 2'd1;
        else if (bus_wdata[2]) bank_q <= 2'd2;
      end
    end
  end

  assign bus_rdata = rdata_q;

  assert_ptr_msb_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_wr && !bus_sel) |=> !bus_rdata[7]);
  assert_step_at_41_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_sel && bank_q == 2'd0 && idx_q == 7'h41) |=> idx_q == 7'h42);
  assert_no_step_at_40_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_sel && idx_q == 7'h40 && !(bus_wr && bus_wdata[7] && bank_q == 2'd0)) |=> idx_q == 7'h40);
  assert_bank_legal_R6: assert property (@(posedge clk) disable iff (rst)
    bank_q != 2'd3);
  assert_init_bank0_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_wr && bus_sel && idx_q == 7'h40 && bus_wdata[7]) |=> bank_q == 2'd0);
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/hwmon_regport_tb.sv
module hwmon_regport_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_wr = 1'b0, bus_sel = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [55:0] volt_in;
  logic [7:0]  temp_main = 8'h1E;
  logic [15:0] temp_aux = {8'h2C, 8'h1B};
  logic [47:0] fan_rpm = {16'd5000, 16'd0, 16'd3000};

  int checks = 0, failures = 0;
  bit done = 0;

  int   m_idx, m_bank;
  int   m_main [32];
  int   m_aux [3][6];
  logic [7:0] m_rdata = 8'h00;

  always #2 clk = ~clk;

  initial for (int k = 0; k < 7; k++) volt_in[8*k +: 8] = 8'(8'h11 + k);

  hwmon_regport u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .volt_in(volt_in),
    .temp_main(temp_main), .temp_aux(temp_aux), .fan_rpm(fan_rpm)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Reference model of the register port, written from the requirements.
  function automatic void m_defaults();
    for (int k = 0; k < 32; k++) m_main[k] = 0;
    m_main['h00] = 'h01; m_main['h06] = 'h40; m_main['h07] = 'h50;
    m_main['h09] = 'h02; m_main['h0B] = 'h44; m_main['h0C] = 'h01;
    m_main['h0D] = 'h15; m_main['h0E] = 'h80; m_main['h17] = 'h80;
    for (int b = 0; b < 3; b++) for (int s = 0; s < 6; s++) m_aux[b][s] = 0;
    m_bank = 0;
  endfunction

  function automatic int m_fan(int rpm, int field);
    int prod, q;
    prod = rpm * (1 << field);
    if (prod == 0) return 255;
    q = 1350000 / prod;
    if (q > 255) return 255;
    if (q < 1) return 1;
    return q;
  endfunction

  function automatic int m_read();
    int i = m_idx;
    if (i < 'h20) return 0;
    if (i <= 'h26) return int'(volt_in[8*(i-'h20) +: 8]);
    if (i == 'h27) return int'(temp_main);
    if (i == 'h28) return m_fan(int'(fan_rpm[15:0]), (m_main['h07] >> 4) & 3);
    if (i == 'h29) return m_fan(int'(fan_rpm[31:16]), (m_main['h07] >> 6) & 3);
    if (i == 'h2A) return m_fan(int'(fan_rpm[47:32]), (m_main['h0B] >> 6) & 3);
    if (i < 'h40) return 0;
    if (m_bank != 0 && i >= 'h50 && i <= 'h5F) begin
      if (i == 'h50) return int'(temp_aux[8*(m_bank-1) +: 8]);
      if (i >= 'h52 && i <= 'h55) return m_aux[m_bank][i-'h50];
      return 0;
    end
    if ((i % 32) == 'h0F) return ((m_main['h0E] & 'h80) != 0) ? 'h5C : 'hA3;
    return m_main[i % 32];
  endfunction

  function automatic void m_write(int d);
    int i = m_idx, e;
    if (m_bank != 0 && i >= 'h50 && i <= 'h5F) begin
      if (i >= 'h52 && i <= 'h55) m_aux[m_bank][i-'h50] = d;
      return;
    end
    if (i < 'h40 || (i >= 'h60 && i <= 'h6A)) return;
    e = i % 32;
    if (e == 'h01 || e == 'h02 || e == 'h0F || e == 'h18) return;
    m_main[e] = d;
    if (e == 'h00 && (d & 'h80) != 0) m_defaults();
    else if (e == 'h0E) begin
      if (d & 1) m_bank = 0;
      else if (d & 2) m_bank = 1;
      else if (d & 4) m_bank = 2;
    end
  endfunction

  function automatic void m_step(bit wr, bit sel, int d);
    int i = m_idx;
    bit steps;
    steps = (m_bank == 0) && (i == 'h41 || i == 'h43 || i == 'h45 || i == 'h56 ||
                              (i >= 'h60 && i <= 'h7E));
    if (!sel) begin
      if (wr) m_idx = d % 128;
      else m_rdata = 8'(m_idx);
    end else begin
      if (wr) m_write(d);
      else m_rdata = 8'(m_read());
      if (steps) m_idx = i + 1;
    end
  endfunction

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) if (!rst && !done) chk("R13 model", bus_rdata, m_rdata);

  task automatic bus(bit wr, bit sel, logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = wr; bus_sel = sel; bus_wdata = d;
    @(posedge clk);
    #1;
    m_step(wr, sel, int'(d));
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_idx(string req, logic [7:0] exp);
    bus(0, 0, 8'h00); @(negedge clk); chk(req, bus_rdata, exp);
  endtask
  task automatic rd_at(string req, logic [7:0] i, logic [7:0] exp);
    bus(1, 0, i); bus(0, 1, 8'h00); @(negedge clk); chk(req, bus_rdata, exp);
  endtask
  task automatic wr_at(logic [7:0] i, logic [7:0] d);
    bus(1, 0, i); bus(1, 1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_idx = 0;
    m_defaults();
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R13 reset rdata", bus_rdata, 8'h00);
    rd_idx("R1 reset pointer", 8'h00);
    // R9 defaults
    rd_at("R9 0x40", 8'h40, 8'h01); rd_at("R9 0x46", 8'h46, 8'h40);
    rd_at("R9 0x47", 8'h47, 8'h50); rd_at("R9 0x49", 8'h49, 8'h02);
    rd_at("R9 0x4B", 8'h4B, 8'h44); rd_at("R9 0x4C", 8'h4C, 8'h01);
    rd_at("R9 0x4D", 8'h4D, 8'h15); rd_at("R9 0x4E", 8'h4E, 8'h80);
    rd_at("R9 0x57", 8'h57, 8'h80); rd_at("R9 0x44", 8'h44, 8'h00);
    // R1 pointer masking
    bus(1, 0, 8'hC5); rd_idx("R1 mask bit7", 8'h45);
    // R2 auto-step
    rd_at("R2 read 0x41", 8'h41, 8'h00); rd_idx("R2 step after 0x41", 8'h42);
    rd_at("R2 read 0x40", 8'h40, 8'h01); rd_idx("R2 no step at 0x40", 8'h40);
    rd_at("R2 read 0x7E", 8'h7E, 8'h00); rd_idx("R2 step at 0x7E", 8'h7F);
    bus(0, 1, 8'h00); rd_idx("R2 no step at 0x7F", 8'h7F);
    wr_at(8'h56, 8'h12); rd_idx("R2 step on write 0x56", 8'h57);
    rd_at("R2 stored 0x56", 8'h56, 8'h12);
    // R3 alias window
    wr_at(8'h6B, 8'hC4); rd_at("R3 alias write 0x6B->0x4B", 8'h4B, 8'hC4);
    rd_at("R3 alias read 0x77", 8'h77, 8'h80);
    rd_at("R11 fan2 div8", 8'h2A, 8'h21);
    // R4 read-only
    wr_at(8'h41, 8'h55); rd_at("R4 0x41 ignored", 8'h41, 8'h00);
    wr_at(8'h47, 8'h30); wr_at(8'h60, 8'h80);
    rd_at("R4 alias 0x60 no init", 8'h47, 8'h30);
    rd_at("R4 cfg untouched", 8'h40, 8'h01);
    wr_at(8'h20, 8'h99); rd_at("R4 sensor ignored", 8'h20, 8'h11);
    wr_at(8'h58, 8'h03); rd_at("R4 0x58 ignored", 8'h58, 8'h00);
    wr_at(8'h4F, 8'h00); rd_at("R5 vid high", 8'h4F, 8'h5C);
    // R11 fan counts with changed divisors
    rd_at("R11 fan0 div8", 8'h28, 8'h38); rd_at("R11 fan1 stopped", 8'h29, 8'hFF);
    // R5 vendor byte select
    wr_at(8'h4E, 8'h00); rd_at("R5 vid low", 8'h4F, 8'hA3);
    rd_at("R5 vid low alias", 8'h6F, 8'hA3);
    wr_at(8'h4E, 8'h80); rd_at("R5 vid high again", 8'h4F, 8'h5C);
    // R6/R7 banks
    wr_at(8'h4E, 8'h86);
    rd_at("R7 bank1 temp", 8'h50, 8'h1B);
    wr_at(8'h52, 8'h77); rd_at("R7 bank1 store", 8'h52, 8'h77);
    wr_at(8'h50, 8'h99); rd_at("R7 0x50 read-only", 8'h50, 8'h1B);
    rd_at("R7 0x51 zero", 8'h51, 8'h00);
    rd_at("R7 0x57 in bank1", 8'h57, 8'h00);
    rd_at("R7 0x56 in bank1", 8'h56, 8'h00); rd_idx("R2 no step in bank1", 8'h56);
    wr_at(8'h72, 8'h3C); rd_at("R7 alias not banked", 8'h72, 8'h3C);
    wr_at(8'h4E, 8'h84);
    rd_at("R6 bank2 separate", 8'h52, 8'h00); rd_at("R7 bank2 temp", 8'h50, 8'h2C);
    wr_at(8'h53, 8'hA5);
    wr_at(8'h4E, 8'h87); rd_at("R6 bit0 priority", 8'h52, 8'h3C);
    wr_at(8'h4E, 8'h80); rd_at("R6 empty keeps bank", 8'h52, 8'h3C);
    wr_at(8'h4E, 8'h82); rd_at("R6 back to bank1", 8'h52, 8'h77);
    // R8 initialization
    wr_at(8'h40, 8'h80); rd_idx("R8 pointer kept", 8'h40);
    rd_at("R8 bank0 after init", 8'h52, 8'h00);
    rd_at("R8 divisor default", 8'h47, 8'h50);
    rd_at("R8 cfg default", 8'h40, 8'h01);
    wr_at(8'h4E, 8'h82); rd_at("R8 bank1 cleared", 8'h52, 8'h00);
    wr_at(8'h4E, 8'h84); rd_at("R8 bank2 cleared", 8'h53, 8'h00);
    wr_at(8'h4E, 8'h81);
    rd_at("R11 fan2 default", 8'h2A, 8'h87);
    rd_at("R11 fan0 default", 8'h28, 8'hE1);
    // R10 sensors
    for (int k = 0; k < 7; k++) rd_at("R10 voltage", 8'(8'h20 + k), 8'(8'h11 + k));
    rd_at("R10 temperature", 8'h27, 8'h1E);
    // R12 unmapped
    rd_at("R12 low range", 8'h10, 8'h00);
    wr_at(8'h30, 8'h44); rd_at("R12 write ignored", 8'h30, 8'h00);
    rd_at("R12 0x3F", 8'h3F, 8'h00);
    // R13 hold
    rd_at("R13 hold setup", 8'h4B, 8'h44);
    repeat (3) @(negedge clk);
    chk("R13 held idle", bus_rdata, 8'h44);
    wr_at(8'h43, 8'h09); @(negedge clk);
    chk("R13 held over write", bus_rdata, 8'h44);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule